// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. Each character goes out as a non-return-to-zero frame: a low start bit, eight or nine data bits with the least significant bit first, and a high stop bit. Between frames the line rests high. Software writes characters into a one-entry holding register. The shift register can only be loaded from that holding register, so the next character can wait there while the current one shifts out. Consecutive characters then leave the block with no idle time between them.

Bit timing comes from an external single-cycle enable pulse, the baud tick. Every bit on the line lasts exactly one tick period. A control register sets the transmitter enable, the word length, the value of the ninth data bit and a break request. While a break is requested, whole frames of zeros go out. Clearing the enable stops new frames from starting but lets the frame already on the line finish. The output-enable pin drops only after that frame ends. Two status flags report that the holding register is empty and that all transmission has finished.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset: `txd` is 1, `txd_oe` is 0, `hold_empty` is 1 and `tx_done` is 1.
- R2: A control write (`wr_ctrl_en`) stores `wr_ctrl`. Bit 0 enables the transmitter. Bit 1 selects nine data bits. Bit 2 is the ninth data bit. Bit 3 requests a break.
- R3: With bit 1 clear, a frame is 10 bit times. The order is start 0, then `wr_data[0]` through `wr_data[7]`, then stop 1.
- R4: With bit 1 set, a frame is 11 bit times. The ninth data bit follows `wr_data[7]`, and the stop 1 comes after it.
- R5: The word length and the ninth data bit are sampled when the holding register transfers to the shifter. Control writes made after that transfer do not change the frame already loaded.
- R6: Frames load only on a baud tick. Each bit holds `txd` constant for exactly one tick period, and `txd` changes only in the cycle after a tick.
- R7: A character written while a frame is shifting starts with its start bit at the tick that ends the previous stop bit. No idle bit time comes between the two frames.
- R8: `hold_empty` goes to 0 the cycle after a data write. It goes to 1 the cycle after the holding register transfers to the shifter.
- R9: `tx_done` goes to 0 on a data write or when any frame starts. It goes to 1 when the shifter finishes a frame and the holding register is empty.
- R10: If the enable is cleared during a frame, that frame completes and `txd_oe` stays 1 until it ends. After that, `txd_oe` is 0 and `txd` is 1. A queued character stays held, with `hold_empty` at 0, until the enable is set again.
- R11: While break and enable are both set, frames of zeros go out, 10 or 11 bit times long depending on bit 1. Break frames take priority over queued data. After the last break frame, one high bit time comes before the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle pulse marking each bit boundary |
| wr_ctrl_en | input | 1 | Control register write strobe |
| wr_ctrl | input | 4 | Control value: break, ninth bit, nine-bit mode, enable (bits 3..0) |
| wr_data_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | High while the block drives the line |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Shifter idle with nothing queued |

## Verification
A wrong bit counter or a bad shift order shows up on `txd` within one frame, as a misplaced stop bit or a swapped data bit. A stuck holding-register flag shows up either as a second character that never starts or as an extra character, at the tick that ends the current stop bit. If the break tail state is lost, the mandatory high bit is missing at the tick after the last zero frame. If the ninth bit or the word length is sampled at the wrong moment, the bit time before the stop bit is wrong.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Control register fields, packed so bit 0 is the enable
  typedef struct packed {
    logic brk;
    logic bit8;
    logic nine;
    logic en;
  } tx_ctl_t;
endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  output logic [DATA_W-1:0] hold_q,
  output logic              hold_full
);
  logic [DATA_W-1:0] data_d;
  logic              full_d;

  always_comb begin
    data_d = hold_q;
    full_d = hold_full;
    if (xfer)  full_d = 1'b0;
    if (wr_en) begin
      data_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      hold_q    <= data_d;
      hold_full <= full_d;
    end
  end

  // R8
  xfer_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en) |=> !hold_full);
  // R8
  write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hold_full);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  tx_ctl_t           ctl,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              xfer,
  output logic              load,
  output logic              finish,
  output logic              busy,
  output logic              txd
);
  localparam int SH_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             busy_d, tail_q, tail_d, at_end;

  assign at_end = busy && (left_q == CNT_W'(1));

  always_comb begin
    busy_d = busy;
    sh_d   = sh_q;
    left_d = left_q;
    tail_d = tail_q;
    xfer   = 1'b0;
    load   = 1'b0;
    if (tick) begin
      if (busy && !at_end) begin
        sh_d   = {1'b1, sh_q[SH_W-1:1]};
        left_d = left_q - CNT_W'(1);
      end else begin
        busy_d = 1'b0;
        if (ctl.en) begin
          if (ctl.brk) begin
            busy_d = 1'b1;
            load   = 1'b1;
            sh_d   = '0;
            left_d = ctl.nine ? CNT_W'(SH_W) : CNT_W'(SH_W - 1);
            tail_d = 1'b1;
          end else if (tail_q) begin
            busy_d = 1'b1;
            load   = 1'b1;
            sh_d   = '1;
            left_d = CNT_W'(1);
            tail_d = 1'b0;
          end else if (hold_full) begin
            busy_d = 1'b1;
            load   = 1'b1;
            xfer   = 1'b1;
            sh_d   = {1'b1, (ctl.nine ? ctl.bit8 : 1'b1), hold_data, 1'b0};
            left_d = ctl.nine ? CNT_W'(SH_W) : CNT_W'(SH_W - 1);
          end
        end
      end
    end
  end

  assign finish = busy && !busy_d;
  assign txd    = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tail_q <= 1'b0;
    end else begin
      busy   <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      tail_q <= tail_d;
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (busy && !txd));
  // R6
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));
  // R6
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));
  // R10
  no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.en && !busy) |=> !busy);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_ctrl_en,
  input  logic [3:0]        wr_ctrl,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              txd_oe,
  output logic              hold_empty,
  output logic              tx_done
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  tx_ctl_t           ctl_q, ctl_d;
  logic              done_d;
  logic              hold_full, xfer, load, finish, busy;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctrl_en) ctl_d = tx_ctl_t'(wr_ctrl);
  end

  always_comb begin
    done_d = tx_done;
    if (finish && !hold_full)  done_d = 1'b1;
    if (wr_data_en || load)    done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q   <= '0;
      tx_done <= 1'b1;
    end else begin
      ctl_q   <= ctl_d;
      tx_done <= done_d;
    end
  end

  uart_tx_holdreg #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_data_en), .wr_data(wr_data),
    .xfer(xfer), .hold_q(hold_q), .hold_full(hold_full)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_i), .tick(baud_tick), .ctl(ctl_q),
    .hold_full(hold_full), .hold_data(hold_q), .xfer(xfer), .load(load),
    .finish(finish), .busy(busy), .txd(txd)
  );

  assign hold_empty = !hold_full;
  assign txd_oe     = busy || ctl_q.en;

  // R9
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(tx_done) |-> hold_empty);
  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_i)
    tx_done |-> !busy);
endmodule

// File: tb/uart_tx_dbuf_tb_top.sv
module uart_tx_dbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int NRND       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_ctrl_en = 1'b0;
  logic [3:0] wr_ctrl = '0;
  logic       wr_data_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txd, txd_oe, hold_empty, tx_done;

  int n_chk = 0;
  int n_bad = 0;
  int tdiv = 0;
  logic expv [0:1023];
  int exp_n = 0;
  int gi = 0;
  logic [7:0] rnd_d [NRND];
  logic [3:0] rnd_c [NRND];

  uart_tx_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .wr_ctrl_en(wr_ctrl_en),
    .wr_ctrl(wr_ctrl), .wr_data_en(wr_data_en), .wr_data(wr_data),
    .txd(txd), .txd_oe(txd_oe), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick <= (tdiv == TICK_DIV - 1);
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
  endtask

  task automatic do_write(logic ce, logic [3:0] c, logic de, logic [7:0] d);
    wait_tick();
    @(negedge clk);
    wr_ctrl_en = ce; wr_ctrl = c; wr_data_en = de; wr_data = d;
    @(negedge clk);
    wr_ctrl_en = 1'b0; wr_data_en = 1'b0;
  endtask

  task automatic clr_exp();
    exp_n = 0; gi = 0;
  endtask

  task automatic push_bit(logic b);
    expv[exp_n] = b;
    exp_n++;
  endtask

  // Expected frame computed from R3/R4: start, data LSB first, optional ninth, stop
  task automatic push_frame(logic nine, logic b8, logic [7:0] d);
    push_bit(1'b0);
    for (int i = 0; i < 8; i++) push_bit(d[i]);
    if (nine) push_bit(b8);
    push_bit(1'b1);
  endtask

  task automatic grab(int n, string tag);
    logic e, l;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      @(negedge clk); e = txd;
      repeat (6) @(negedge clk);
      l = txd;
      chk(tag, l, expv[gi]);
      chk("R6 bit constant over tick period", e, l);
      gi++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1771));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1'b1);
    chk("R1 txd_oe", txd_oe, 1'b0);
    chk("R1 hold_empty", hold_empty, 1'b1);
    chk("R1 tx_done", tx_done, 1'b1);

    // R2 R3 eight-bit frame, enable via control bit 0
    clr_exp(); push_frame(1'b0, 1'b0, 8'hA5); push_bit(1'b1); push_bit(1'b1);
    do_write(1'b1, 4'b0001, 1'b1, 8'hA5);
    chk("R8 empty clears on write", hold_empty, 1'b0);
    chk("R9 done clears on write", tx_done, 1'b0);
    chk("R2 enable drives oe", txd_oe, 1'b1);
    grab(12, "R3 eight-bit frame");
    chk("R9 done after frame", tx_done, 1'b1);
    chk("R8 empty after frame", hold_empty, 1'b1);

    // R7 R8 back-to-back through holding register
    clr_exp(); push_frame(1'b0, 1'b0, 8'h3C); push_frame(1'b0, 1'b0, 8'hC3); push_bit(1'b1);
    do_write(1'b0, 4'b0000, 1'b1, 8'h3C);
    fork
      grab(21, "R7 back-to-back");
      begin
        wait_tick(); @(negedge clk);
        chk("R8 empty after transfer", hold_empty, 1'b1);
        chk("R9 done low while busy", tx_done, 1'b0);
        do_write(1'b0, 4'b0000, 1'b1, 8'hC3);
        chk("R8 empty clears on queued write", hold_empty, 1'b0);
      end
    join
    chk("R9 done after pair", tx_done, 1'b1);

    // R4 nine-bit frames, ninth bit 1 then 0
    clr_exp(); push_frame(1'b1, 1'b1, 8'h5A); push_bit(1'b1);
    do_write(1'b1, 4'b0111, 1'b1, 8'h5A);
    grab(12, "R4 nine-bit b8=1");
    clr_exp(); push_frame(1'b1, 1'b0, 8'h0F); push_bit(1'b1);
    do_write(1'b1, 4'b0011, 1'b1, 8'h0F);
    grab(12, "R4 nine-bit b8=0");

    // R5 control change after transfer does not alter the frame
    clr_exp(); push_frame(1'b1, 1'b1, 8'h81); push_bit(1'b1);
    do_write(1'b1, 4'b0111, 1'b1, 8'h81);
    fork
      grab(12, "R5 sampled at transfer");
      begin
        wait_tick(); @(negedge clk);
        do_write(1'b1, 4'b0001, 1'b0, 8'h00);
      end
    join

    // R10 disable during a frame
    clr_exp(); push_frame(1'b0, 1'b0, 8'h99);
    do_write(1'b0, 4'b0000, 1'b1, 8'h99);
    fork
      grab(10, "R10 frame completes");
      begin
        repeat (3) wait_tick();
        do_write(1'b1, 4'b0000, 1'b1, 8'h42);
        chk("R10 oe held in frame", txd_oe, 1'b1);
      end
    join
    wait_tick(); @(negedge clk);
    chk("R10 oe released", txd_oe, 1'b0);
    chk("R10 line high", txd, 1'b1);
    chk("R10 queued held", hold_empty, 1'b0);
    clr_exp(); push_bit(1'b1); push_bit(1'b1); push_bit(1'b1);
    grab(3, "R10 nothing sent while off");
    clr_exp(); push_frame(1'b0, 1'b0, 8'h42); push_bit(1'b1);
    do_write(1'b1, 4'b0001, 1'b0, 8'h00);
    grab(11, "R10 queued sent on enable");

    // R11 break, two eight-bit break frames, guard bit, then queued data
    clr_exp();
    for (int i = 0; i < 20; i++) push_bit(1'b0);
    push_bit(1'b1); push_frame(1'b0, 1'b0, 8'hE7);
    do_write(1'b1, 4'b1001, 1'b0, 8'h00);
    fork
      grab(31, "R11 break then data");
      begin
        repeat (14) wait_tick();
        do_write(1'b1, 4'b0001, 1'b1, 8'hE7);
      end
    join

    // R11 nine-bit break frame is 11 bit times
    clr_exp();
    for (int i = 0; i < 11; i++) push_bit(1'b0);
    push_bit(1'b1); push_bit(1'b1); push_bit(1'b1);
    do_write(1'b1, 4'b1011, 1'b0, 8'h00);
    fork
      grab(14, "R11 nine-bit break");
      begin
        repeat (6) wait_tick();
        do_write(1'b1, 4'b0011, 1'b0, 8'h00);
      end
    join

    // Random stream, back-to-back, per-frame word length and ninth bit (R3 R4 R7)
    clr_exp();
    for (int k = 0; k < NRND; k++) begin
      rnd_d[k] = 8'($urandom);
      rnd_c[k] = {1'b0, 1'($urandom), 1'($urandom), 1'b1};
      push_frame(rnd_c[k][1], rnd_c[k][2], rnd_d[k]);
    end
    push_bit(1'b1);
    do_write(1'b1, rnd_c[0], 1'b1, rnd_d[0]);
    fork
      grab(exp_n, "R7 random stream");
      begin
        for (int k = 1; k < NRND; k++) begin
          @(negedge clk);
          while (!hold_empty) @(negedge clk);
          do_write(1'b1, rnd_c[k], 1'b1, rnd_d[k]);
        end
      end
    join
    chk("R9 done after stream", tx_done, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule